// File: doc/BRIEF.md
# Multichannel Waveform Zero-Suppression Compactor

This block turns a full digitizer record into a sparse list of 32-bit words. A record holds `NUM_BINS` samples for each of `NUM_CH` channels. The samples arrive one per clock, with channel 0 first and the bins of each channel in ascending order. Each channel has its own stored pedestal, and a saturating subtraction takes it off every incoming sample. The result is then tested against one global threshold. A sample survives only when it is above the threshold and at least one of its neighbouring bins in the same channel is also above it. This removes lone spikes and flat baseline in a single pass.

Each surviving sample is tagged with its channel and bin, packed into a word and written to an internal buffer. After the last sample, the block pulses a completion flag and presents the word count. The buffer can then be drained as one contiguous burst over a ready/valid read port, and the final word carries an end-of-block flag.

The controller is a four-state machine:
- `ST_IDLE` goes to `ST_ACQUIRE` on `start`.
- `ST_ACQUIRE` goes to `ST_FLUSH` when the final sample of the record is accepted.
- `ST_FLUSH` goes to `ST_READOUT` unconditionally, after one cycle that settles the last bin of the last channel.
- `ST_READOUT` goes to `ST_IDLE` on the handshake of the final word, or at once when the buffer is empty.

Pedestals and the threshold are loaded through a simple synchronous write port. `NUM_CH` may be at most 16 and `NUM_BINS` at most 256, so that the identifiers fit their fields.

Top module: `zsc_compactor`

## Requirements
- R1: After reset, `in_ready`, `rd_valid`, `rd_last` and `rec_done` are low and `word_count` is 0; all pedestals and the threshold are 0.
- R2: A write with `reg_addr` below `NUM_CH` loads the pedestal of that channel, and `reg_addr` equal to `NUM_CH` loads the threshold. Writes to any higher address change nothing.
- R3: The corrected sample is the raw sample minus its channel's pedestal, or 0 when the raw sample is not greater than the pedestal.
- R4: A sample whose corrected value is at or below the threshold is never emitted.
- R5: An above-threshold sample is emitted only if the previous or the next bin of the same channel is also above threshold. A bin outside the channel counts as not above, so lone samples, including those at bin 0 and at the last bin, are dropped.
- R6: Each word is laid out as channel in bits 31:28, bin in bits 27:20, zeros in bits 19:8 and the corrected sample in bits 7:0, with the identifiers zero-extended.
- R7: Words are stored and read out in ascending channel order, and in ascending bin order within a channel.
- R8: `start` in `ST_IDLE` begins a record and raises `in_ready`. Exactly `NUM_CH*NUM_BINS` samples are taken, on cycles with `in_valid` and `in_ready` high. `in_valid` while `in_ready` is low has no effect.
- R9: Two clock edges after the final sample is accepted, `rec_done` is high for one cycle and `word_count` holds the number of stored words for the record.
- R10: In `ST_READOUT`, `rd_valid` presents the stored words in order and holds `rd_data` while `rd_ready` is low. `rd_last` is high with the final word, and after its handshake `rd_valid` and `in_ready` are low. A record with no words gives no `rd_valid` at all.
- R11: At most `BUF_DEPTH` words are stored. Surviving samples beyond that are dropped, and `word_count` saturates at `BUF_DEPTH`.
- R12: `start` outside `ST_IDLE` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_addr | input | $clog2(NUM_CH+1) | Configuration address: a channel pedestal, or `NUM_CH` for the threshold |
| reg_wdata | input | 8 | Configuration write data |
| start | input | 1 | Begin a new record (honoured only when idle) |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 8 | Raw digitized sample |
| in_ready | output | 1 | High while samples are being accepted |
| rec_done | output | 1 | One-cycle pulse: record compacted, count final |
| word_count | output | $clog2(BUF_DEPTH+1) | Number of words stored for the last record |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Read consumer accepts the word |
| rd_data | output | 32 | Packed output word |
| rd_last | output | 1 | End-of-block flag on the final word |

## Verification
The bench builds the block with `NUM_CH=4`, `NUM_BINS=8` and `BUF_DEPTH=16`. With these values a record is only 32 samples long, so the buffer can be overfilled within one record and the saturated count can be observed directly. The short records also place every channel boundary, both edge bins and the unused configuration addresses within reach of a few directed scenarios. These scenarios include gaps in the sample stream and back-pressure on the read port.

// File: rtl/zsc_pkg.sv
package zsc_pkg;

    localparam int SAMPLE_W    = 8;
    localparam int WORD_W      = 32;
    localparam int CH_FIELD_W  = 4;
    localparam int BIN_FIELD_W = 8;
    localparam int PAD_W       = WORD_W - CH_FIELD_W - BIN_FIELD_W - SAMPLE_W;

    typedef logic [SAMPLE_W-1:0]    sample_t;
    typedef logic [WORD_W-1:0]      word_t;
    typedef logic [CH_FIELD_W-1:0]  ch_field_t;
    typedef logic [BIN_FIELD_W-1:0] bin_field_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQUIRE,
        ST_FLUSH,
        ST_READOUT
    } zsc_state_e;

    function automatic sample_t sat_sub(sample_t raw, sample_t base);
        return (raw > base) ? sample_t'(raw - base) : '0;
    endfunction

    function automatic word_t pack_word(ch_field_t ch, bin_field_t bin, sample_t val);
        return {ch, bin, {PAD_W{1'b0}}, val};
    endfunction

endpackage

// File: rtl/zsc_cfg_regs.sv
module zsc_cfg_regs
    import zsc_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int AW   = $clog2(NUM_CH + 1),
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  sample_t         wdata,
    input  logic [CH_W-1:0] ch_sel,
    output sample_t         ped_sel,
    output sample_t         thr
);

    sample_t ped_q [NUM_CH];
    sample_t thr_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ped
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ped_q[g] <= '0;
            end else if (we && addr == AW'(g)) begin
                ped_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (we && addr == AW'(NUM_CH)) begin
            thr_q <= wdata;
        end
    end

    assign ped_sel = ped_q[ch_sel];
    assign thr     = thr_q;

    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == AW'(NUM_CH)) |=> $stable(thr_q)); // R2

endmodule

// File: rtl/zsc_spike_filter.sv
module zsc_spike_filter
    import zsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s_valid,
    input  sample_t    s_raw,
    input  sample_t    s_ped,
    input  sample_t    s_thr,
    input  ch_field_t  s_ch,
    input  bin_field_t s_bin,
    input  logic       s_first,
    input  logic       s_last,
    output logic       emit,
    output word_t      emit_word
);

    sample_t    corr;
    logic       above;

    sample_t    mid_val_q;
    logic       mid_abv_q;
    ch_field_t  mid_ch_q;
    bin_field_t mid_bin_q;
    logic       prev_abv_q;
    logic       tail_pend_q;

    logic       mid_keep;
    logic       tail_keep;

    always_comb begin
        corr  = sat_sub(s_raw, s_ped);
        above = corr > s_thr;
    end

    // The middle sample is decided when its right neighbour arrives;
    // the last bin of a channel is decided one cycle after it arrives.
    always_comb begin
        mid_keep  = s_valid && !s_first && mid_abv_q && (prev_abv_q || above);
        tail_keep = tail_pend_q && mid_abv_q && prev_abv_q;
        emit      = mid_keep || tail_keep;
        emit_word = pack_word(mid_ch_q, mid_bin_q, mid_val_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_val_q   <= '0;
            mid_abv_q   <= 1'b0;
            mid_ch_q    <= '0;
            mid_bin_q   <= '0;
            prev_abv_q  <= 1'b0;
            tail_pend_q <= 1'b0;
        end else begin
            tail_pend_q <= s_valid && s_last;
            if (s_valid) begin
                prev_abv_q <= s_first ? 1'b0 : mid_abv_q;
                mid_val_q  <= corr;
                mid_abv_q  <= above;
                mid_ch_q   <= s_ch;
                mid_bin_q  <= s_bin;
            end
        end
    end

    AST_EMIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (emit_word[SAMPLE_W-1:0] != '0)); // R4

    AST_TAIL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        tail_pend_q |-> !(s_valid && !s_first)); // R5

endmodule

// File: rtl/zsc_word_buffer.sv
module zsc_word_buffer
    import zsc_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  word_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_data,
    output logic [CNT_W-1:0]  count
);

    word_t            mem [DEPTH];
    logic [CNT_W-1:0] count_q;
    logic             has_room;

    assign has_room = count_q < CNT_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (wr_en && has_room && !clear) begin
            mem[count_q[ADDR_W-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (wr_en && has_room) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign rd_data = mem[rd_addr];
    assign count   = count_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH)); // R11

    AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_W'(DEPTH) && !clear) |=> count_q == CNT_W'(DEPTH)); // R11

endmodule

// File: rtl/zsc_compactor.sv
module zsc_compactor
    import zsc_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int NUM_BINS  = 256,
    parameter int BUF_DEPTH = 1024,
    localparam int REG_AW = $clog2(NUM_CH + 1),
    localparam int CNT_W  = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              start,
    input  logic              in_valid,
    input  logic [7:0]        in_sample,
    output logic              in_ready,
    output logic              rec_done,
    output logic [CNT_W-1:0]  word_count,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [31:0]       rd_data,
    output logic              rd_last
);

    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int BIN_W  = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1;
    localparam int ADDR_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

    zsc_state_e state_q, state_d;

    logic [CH_W-1:0]  ch_q;
    logic [BIN_W-1:0] bin_q;
    logic [CNT_W-1:0] rd_ptr_q;
    logic             rec_done_q;

    logic             start_ok;
    logic             accept;
    logic             bin_last;
    logic             rec_last;
    logic             rd_fire;
    logic             buf_clear;

    sample_t          ped_cur;
    sample_t          thr_cur;
    logic             flt_emit;
    word_t            flt_word;
    word_t            buf_rd_data;
    logic [CNT_W-1:0] buf_count;

    // ---------------- configuration ----------------
    zsc_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .ch_sel  (ch_q),
        .ped_sel (ped_cur),
        .thr     (thr_cur)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_ACQUIRE;
            ST_ACQUIRE: if (accept && rec_last) state_d = ST_FLUSH;
            ST_FLUSH:   state_d = ST_READOUT;
            ST_READOUT: if ((rd_fire && rd_last) || buf_count == '0) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs and strobes ----------------
    always_comb begin
        bin_last  = bin_q == BIN_W'(NUM_BINS - 1);
        rec_last  = bin_last && (ch_q == CH_W'(NUM_CH - 1));
        start_ok  = (state_q == ST_IDLE) && start;
        in_ready  = (state_q == ST_ACQUIRE);
        accept    = in_ready && in_valid;
        buf_clear = start_ok;
        rd_valid  = (state_q == ST_READOUT) && (rd_ptr_q != buf_count);
        rd_last   = rd_valid && (rd_ptr_q == buf_count - CNT_W'(1));
        rd_fire   = rd_valid && rd_ready;
        rd_data   = buf_rd_data;
        rec_done  = rec_done_q;
        word_count = buf_count;
    end

    // ---------------- scan counters and read pointer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q       <= '0;
            bin_q      <= '0;
            rd_ptr_q   <= '0;
            rec_done_q <= 1'b0;
        end else begin
            rec_done_q <= (state_q == ST_FLUSH);
            if (start_ok) begin
                ch_q     <= '0;
                bin_q    <= '0;
                rd_ptr_q <= '0;
            end else begin
                if (accept) begin
                    if (bin_last) begin
                        bin_q <= '0;
                        ch_q  <= rec_last ? '0 : ch_q + CH_W'(1);
                    end else begin
                        bin_q <= bin_q + BIN_W'(1);
                    end
                end
                if (rd_fire) begin
                    rd_ptr_q <= rd_ptr_q + CNT_W'(1);
                end
            end
        end
    end

    // ---------------- datapath ----------------
    zsc_spike_filter u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (accept),
        .s_raw     (in_sample),
        .s_ped     (ped_cur),
        .s_thr     (thr_cur),
        .s_ch      (CH_FIELD_W'(ch_q)),
        .s_bin     (BIN_FIELD_W'(bin_q)),
        .s_first   (bin_q == '0),
        .s_last    (bin_last),
        .emit      (flt_emit),
        .emit_word (flt_word)
    );

    zsc_word_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (buf_clear),
        .wr_en   (flt_emit),
        .wr_data (flt_word),
        .rd_addr (rd_ptr_q[ADDR_W-1:0]),
        .rd_data (buf_rd_data),
        .count   (buf_count)
    );

    // ---------------- assertions ----------------
    AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        flt_emit |-> (state_q == ST_ACQUIRE || state_q == ST_FLUSH)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> !rec_done); // R9

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R10

    AST_READ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !in_ready); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READOUT && start && !rd_fire && buf_count != '0) |=> state_q == ST_READOUT); // R12

endmodule

// File: tb/zsc_compactor_bench.sv
module zsc_compactor_bench;

    localparam int NC  = 4;
    localparam int NB  = 8;
    localparam int BD  = 16;
    localparam int TOT = NC * NB;
    localparam int AW  = $clog2(NC + 1);
    localparam int CW  = $clog2(BD + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_sample = '0;
    logic          in_ready;
    logic          rec_done;
    logic [CW-1:0] word_count;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [31:0]   rd_data;
    logic          rd_last;

    int n_checks = 0;
    int n_fails  = 0;
    bit reported = 0;

    logic [7:0]  smp   [TOT];
    logic [7:0]  m_ped [NC];
    logic [7:0]  m_thr;
    logic [31:0] exp_w [BD];
    int          exp_n;

    always #10 clk = ~clk;

    zsc_compactor #(.NUM_CH(NC), .NUM_BINS(NB), .BUF_DEPTH(BD)) u_zsc_compactor (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .start(start), .in_valid(in_valid),
        .in_sample(in_sample), .in_ready(in_ready), .rec_done(rec_done),
        .word_count(word_count), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_last(rd_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        report();
        $finish;
    end

    // Reference: R3 correction, R4 threshold, R5 neighbours, R6 layout, R7 order, R11 cap
    function automatic logic [7:0] corr_of(int i);
        int ch = i / NB;
        return (smp[i] > m_ped[ch]) ? 8'(smp[i] - m_ped[ch]) : 8'h00;
    endfunction

    function automatic bit above_of(int i);
        return corr_of(i) > m_thr;
    endfunction

    function automatic void build_expected();
        exp_n = 0;
        for (int ch = 0; ch < NC; ch++) begin
            for (int b = 0; b < NB; b++) begin
                int  i = ch * NB + b;
                bit  l = (b > 0) && above_of(i - 1);
                bit  r = (b < NB - 1) && above_of(i + 1);
                if (above_of(i) && (l || r) && exp_n < BD) begin
                    exp_w[exp_n] = {4'(ch), 8'(b), 12'h000, corr_of(i)};
                    exp_n++;
                end
            end
        end
    endfunction

    task automatic write_reg(input int addr, input logic [7:0] val);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = AW'(addr);
        reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
        if (addr < NC) m_ped[addr] = val;
        else if (addr == NC) m_thr = val;
    endtask

    // Drive one record, wait for completion, drain and compare.
    task automatic run_record(input string name, input bit gaps, input bit backpressure,
                              input bit poke_start);
        int guard;
        int idx;
        int cyc;
        build_expected();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(in_ready === 1'b1, "R8", {name, " in_ready after start"}, in_ready, 1);
        for (int i = 0; i < TOT; i++) begin
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                in_sample = 8'hEE;
                @(negedge clk);
            end
            in_valid  = 1'b1;
            in_sample = smp[i];
            start     = poke_start && (i == TOT / 2); // R12: ignored mid-record
            @(negedge clk);
        end
        in_valid = 1'b0;
        start    = 1'b0;
        check(rec_done === 1'b0, "R9", {name, " rec_done one edge after last"}, rec_done, 0);
        @(negedge clk);
        check(rec_done === 1'b1, "R9", {name, " rec_done two edges after last"}, rec_done, 1);
        check(word_count == CW'(exp_n), "R9", {name, " word_count"}, word_count, exp_n);
        idx = 0;
        cyc = 0;
        guard = 0;
        while (idx < exp_n && guard < 400) begin
            bit rdy = backpressure ? (cyc % 3 != 0) : 1'b1;
            if (backpressure && poke_start && idx == 1) start = 1'b1; // R12
            else start = 1'b0;
            if (rd_valid && rdy) begin
                check(rd_data == exp_w[idx], "R7", $sformatf("%s word %0d", name, idx),
                      rd_data, exp_w[idx]);
                check(rd_last == (idx == exp_n - 1), "R10", $sformatf("%s last flag %0d", name, idx),
                      rd_last, (idx == exp_n - 1));
                idx++;
            end
            rd_ready = rdy;
            @(negedge clk);
            cyc++;
            guard++;
        end
        rd_ready = 1'b0;
        start    = 1'b0;
        check(idx == exp_n, "R10", {name, " words drained"}, idx, exp_n);
        repeat (2) @(negedge clk);
        check(rd_valid === 1'b0, "R10", {name, " rd_valid low after block"}, rd_valid, 0);
        check(in_ready === 1'b0, "R10", {name, " idle after block"}, in_ready, 0);
    endtask

    task automatic test_reset();
        check(in_ready === 1'b0 && rd_valid === 1'b0, "R1", "in_ready/rd_valid at reset",
              {in_ready, rd_valid}, 0);
        check(rd_last === 1'b0 && rec_done === 1'b0, "R1", "rd_last/rec_done at reset",
              {rd_last, rec_done}, 0);
        check(word_count == '0, "R1", "word_count at reset", word_count, 0);
    endtask

    task automatic test_config_and_basic();
        write_reg(0, 8'd10);
        write_reg(1, 8'd20);
        write_reg(2, 8'd0);
        write_reg(3, 8'd5);
        write_reg(NC, 8'd3);
        // R2: addresses above NUM_CH must not touch any setting
        for (int a = NC + 1; a < (1 << AW); a++) begin
            @(negedge clk);
            reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = 8'hFF;
            @(negedge clk);
            reg_we = 1'b0;
        end
        // R8: samples offered while idle have no effect
        @(negedge clk);
        in_valid = 1'b1; in_sample = 8'hFF;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        smp = '{8'd20, 8'd9, 8'd30, 8'd31, 8'd5, 8'd10, 8'd15, 8'd16,
                8'd0, 8'd19, 8'd25, 8'd200, 8'd22, 8'd21, 8'd30, 8'd24,
                8'd3, 8'd4, 8'd4, 8'd0, 8'd9, 8'd0, 8'd8, 8'd9,
                8'd255, 8'd255, 8'd0, 8'd7, 8'd8, 8'd9, 8'd0, 8'd250};
        run_record("basic R2 R3 R4 R5 R6", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_spikes_gaps_backpressure();
        write_reg(NC, 8'd30);
        for (int i = 0; i < TOT; i++) smp[i] = 8'((i * 53 + 7) % 97);
        run_record("spike R5 gaps backpressure R12", 1'b1, 1'b1, 1'b1);
    endtask

    task automatic test_empty_record();
        write_reg(NC, 8'd255);
        for (int i = 0; i < TOT; i++) smp[i] = 8'd255;
        run_record("empty R4 R10", 1'b0, 1'b0, 1'b0);
        check(exp_n == 0, "R10", "empty record expectation", exp_n, 0);
    endtask

    task automatic test_overflow();
        for (int c = 0; c < NC; c++) write_reg(c, 8'd0);
        write_reg(NC, 8'd0);
        for (int i = 0; i < TOT; i++) smp[i] = 8'(50 + i);
        run_record("overflow R11", 1'b0, 1'b1, 1'b0);
        check(exp_n == BD, "R11", "overflow capped expectation", exp_n, BD);
    endtask

    initial begin
        m_thr = '0;
        for (int c = 0; c < NC; c++) m_ped[c] = '0;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_config_and_basic();
        test_spikes_gaps_backpressure();
        test_empty_record();
        test_overflow();
        report();
        $finish;
    end

endmodule